// File: doc/BRIEF.md
# Reference Clock Output Controller

This block generates a divided reference clock from one of eight tick sources that share a single clock domain. Software programs it through a two-word register bus. The control word sets the source, the master enable and the pin drive. It also sets whether the clock keeps running while the chip is in idle or sleep, and it carries a request bit for changing the divisor. The divisor word holds a 15-bit pending divisor. It takes effect only at a safe point: at a counter wrap while the clock runs, or at once while the clock is stopped.

A live status bit in the control word reports whether the reference clock is running. While that bit is set, the hardware refuses writes to the source field. Software therefore stops the clock, waits for the status to drop, and only then selects a new source.

Top module: `refclk_ctrl`

## Requirements
- R1: After reset both registers read 0x0000, and `ref_clk`, `ref_pin` and `ref_active` are 0.
- R2: Control bit 15 is the master enable. `ref_active` is 1 only when bit 15 is 1, the selected source is valid, and no stop condition applies. Control bit 8 reads back `ref_active` and ignores writes.
- R3: Control bit 13 is the idle-run bit. When it is 0 and `idle_req` is 1, the clock is stopped (`ref_active` is 0). When it is 1, `idle_req` has no effect.
- R4: Control bit 11 is the sleep-run bit. When it is 0 and `sleep_req` is 1, the clock is stopped. When it is 1, `sleep_req` has no effect.
- R5: Control bits 3:0 pick the source. Code k in 0..7 uses `src_tick[k]`. Codes 8..15 produce no ticks, keep `ref_clk` low and force `ref_active` to 0.
- R6: Control bit 12 enables the pin. When it is 0, `ref_pin` stays 0 while `ref_clk` may still toggle. When it is 1, `ref_pin` follows `ref_clk`.
- R7: A write to the control word leaves bits 3:0 unchanged when `ref_active` is 1 at that write. The other fields are still updated.
- R8: Control bits 14, 10 and 7:4 read as 0 whatever is written. Bit 15 of the divisor word reads as 0.
- R9: With an active divisor of 0, `ref_clk` is high for exactly the cycle after each selected tick. With a divisor N > 0, `ref_clk` toggles every N selected ticks.
- R10: Writing 1 to control bit 9 sets a pending request (writing 0 does not cancel it). The divisor word (address 1, bits 14:0) is loaded when a wrap occurs, or on the next cycle if the clock is stopped. Bit 9 clears on the cycle of the load, so no phase is shortened.
- R11: Once `ref_active` is 0, `ref_clk` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 divisor |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| src_tick | input | 8 | One tick enable per source |
| idle_req | input | 1 | Chip is in idle mode |
| sleep_req | input | 1 | Chip is in sleep mode |
| ref_clk | output | 1 | Internal reference clock |
| ref_pin | output | 1 | Reference clock on the pin, gated by the pin enable |
| ref_active | output | 1 | Reference clock running |

## Verification
On every cycle the assertions check the following: the idle and sleep stop conditions, the ban on reserved source codes, the source-write guard, the reserved bits reading zero, the output going low after a stop, the pin never running ahead of the internal clock, and that a falling request always comes with the pending divisor being loaded. Only the bench scenarios can show the actual division ratios, the passthrough mode, that a divisor change waits for a wrap and never produces a short phase, and that each source code routes the right tick input.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    parameter int CTRL_W = 16;
    parameter int DIV_W  = 15;
    parameter int SEL_W  = 4;

    // Control word bit positions (software-visible layout)
    localparam int EN_B    = 15;
    localparam int IDLE_B  = 13;
    localparam int PIN_B   = 12;
    localparam int SLEEP_B = 11;
    localparam int REQ_B   = 9;
    localparam int ACT_B   = 8;

    typedef enum logic [SEL_W-1:0] {
        SRC_SYSCLK = 4'd0,
        SRC_PERCLK = 4'd1,
        SRC_XTAL   = 4'd2,
        SRC_FASTRC = 4'd3,
        SRC_SLOWRC = 4'd4,
        SRC_BKUPRC = 4'd5,
        SRC_PLLQ   = 4'd6,
        SRC_EXTIN  = 4'd7
    } src_e;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_DIV  = 1'b1
    } addr_e;

    typedef struct packed {
        logic             en;
        logic             idle_run;
        logic             pin_en;
        logic             sleep_run;
        logic             div_req;
        logic [SEL_W-1:0] src;
    } ctrl_t;

    function automatic logic src_ok(input logic [SEL_W-1:0] s, input int nsrc);
        return int'(s) < nsrc;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c, input logic act);
        logic [CTRL_W-1:0] w;
        w          = '0;
        w[EN_B]    = c.en;
        w[IDLE_B]  = c.idle_run;
        w[PIN_B]   = c.pin_en;
        w[SLEEP_B] = c.sleep_run;
        w[REQ_B]   = c.div_req;
        w[ACT_B]   = act;
        w[SEL_W-1:0] = c.src;
        return w;
    endfunction

endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
    import refclk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              active,
    input  logic              div_loaded,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     div_pend,
    output logic [CTRL_W-1:0] rdata
);

    logic wr_ctrl, wr_div;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_div  = wr && (addr == ADDR_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            div_pend <= '0;
        end else begin
            if (div_loaded)
                ctrl.div_req <= 1'b0;
            if (wr_ctrl) begin
                ctrl.en        <= wdata[EN_B];
                ctrl.idle_run  <= wdata[IDLE_B];
                ctrl.pin_en    <= wdata[PIN_B];
                ctrl.sleep_run <= wdata[SLEEP_B];
                if (wdata[REQ_B])
                    ctrl.div_req <= 1'b1;
                if (!active)
                    ctrl.src <= wdata[SEL_W-1:0];
            end
            if (wr_div)
                div_pend <= wdata[DW-1:0];
        end
    end

    always_comb begin
        if (addr == ADDR_CTRL)
            rdata = pack_ctrl(ctrl, active);
        else
            rdata = CTRL_W'(div_pend);
    end

endmodule

// File: rtl/refclk_srcmux.sv
module refclk_srcmux
    import refclk_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] src_tick,
    input  ctrl_t           ctrl,
    input  logic            idle_req,
    input  logic            sleep_req,
    output logic            tick,
    output logic            run
);

    logic [NSRC-1:0] hit;
    logic            idle_ok, sleep_ok;

    for (genvar k = 0; k < NSRC; k++) begin : g_lane
        assign hit[k] = src_tick[k] && (ctrl.src == SEL_W'(k));
    end

    assign idle_ok  = ctrl.idle_run  || !idle_req;
    assign sleep_ok = ctrl.sleep_run || !sleep_req;
    assign run      = ctrl.en && src_ok(ctrl.src, NSRC) && idle_ok && sleep_ok;
    assign tick     = run && (|hit);

endmodule

// File: rtl/refclk_divider.sv
module refclk_divider #(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          req,
    input  logic [DW-1:0] div_pend,
    output logic          clk_out,
    output logic          loaded,
    output logic [DW-1:0] div_cur
);

    logic [DW-1:0] cnt;
    logic          pass, at_end, wrap;

    assign pass   = (div_cur == '0);
    assign at_end = (cnt == DW'(div_cur - 1'b1));
    assign wrap   = tick && (pass || at_end);
    assign loaded = req && (!run || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_cur <= '0;
            clk_out <= 1'b0;
        end else begin
            if (!run) begin
                clk_out <= 1'b0;
                cnt     <= '0;
            end else if (tick) begin
                if (pass) begin
                    clk_out <= 1'b1;
                end else if (at_end) begin
                    clk_out <= ~clk_out;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (pass) begin
                clk_out <= 1'b0;
            end
            if (loaded) begin
                div_cur <= div_pend;
                cnt     <= '0;
            end
        end
    end

endmodule

// File: rtl/refclk_ctrl.sv
module refclk_ctrl
    import refclk_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              idle_req,
    input  logic              sleep_req,
    output logic              ref_clk,
    output logic              ref_pin,
    output logic              ref_active
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] div_pend;
    logic [DW-1:0] div_cur;
    logic          div_loaded;
    logic          sel_tick;
    logic          run;

    refclk_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .active     (run),
        .div_loaded (div_loaded),
        .ctrl       (ctrl_q),
        .div_pend   (div_pend),
        .rdata      (bus_rdata)
    );

    refclk_srcmux #(.NSRC(NSRC)) u_mux (
        .src_tick  (src_tick),
        .ctrl      (ctrl_q),
        .idle_req  (idle_req),
        .sleep_req (sleep_req),
        .tick      (sel_tick),
        .run       (run)
    );

    refclk_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (sel_tick),
        .req      (ctrl_q.div_req),
        .div_pend (div_pend),
        .clk_out  (ref_clk),
        .loaded   (div_loaded),
        .div_cur  (div_cur)
    );

    assign ref_active = run;
    assign ref_pin    = ref_clk && ctrl_q.pin_en;

endmodule

// File: rtl/refclk_chk.sv
module refclk_chk
    import refclk_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = DIV_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic              addr,
    input logic [CTRL_W-1:0] rdata,
    input logic              active,
    input logic              ref_clk,
    input logic              ref_pin,
    input logic              idle,
    input logic              sleep,
    input ctrl_t             ctrl,
    input logic [DW-1:0]     div_cur,
    input logic [DW-1:0]     div_pend
);

    // R3
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !ctrl.idle_run) |-> !active);

    // R4
    sleep_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep && !ctrl.sleep_run) |-> !active);

    // R5
    rsvd_src_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ctrl.src) >= NSRC) |-> !active);

    // R6
    pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ref_pin |-> ref_clk);

    // R7
    src_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (active && wr && addr == 1'b0) |=> (ctrl.src == $past(ctrl.src)));

    // R8
    rsvd_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 1'b0) |-> (rdata[14] == 1'b0 && rdata[10] == 1'b0 && rdata[7:4] == 4'd0));

    // R10
    req_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.div_req) |-> (div_cur == $past(div_pend)));

    // R11
    stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !ref_clk);

endmodule

bind refclk_ctrl refclk_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .rdata    (bus_rdata),
    .active   (ref_active),
    .ref_clk  (ref_clk),
    .ref_pin  (ref_pin),
    .idle     (idle_req),
    .sleep    (sleep_req),
    .ctrl     (ctrl_q),
    .div_cur  (div_cur),
    .div_pend (div_pend)
);

// File: tb/refclk_ctrl_test.sv
module refclk_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  src_tick = '0;
    logic        idle_req = 1'b0;
    logic        sleep_req = 1'b0;
    logic        ref_clk, ref_pin, ref_active;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    refclk_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .idle_req(idle_req), .sleep_req(sleep_req), .ref_clk(ref_clk),
        .ref_pin(ref_pin), .ref_active(ref_active)
    );

    // {wdata[34:19], idle[18], sleep[17], exp_rdata[16:1], exp_active[0]}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},  // R2 disabled
        {16'h8001, 1'b0, 1'b0, 16'h8101, 1'b1},  // R2 enable
        {16'h8001, 1'b1, 1'b0, 16'h8001, 1'b0},  // R3 idle stops
        {16'hA001, 1'b1, 1'b0, 16'hA101, 1'b1},  // R3 idle run
        {16'hA001, 1'b0, 1'b1, 16'hA001, 1'b0},  // R4 sleep stops
        {16'hA801, 1'b0, 1'b1, 16'hA901, 1'b1},  // R4 sleep run
        {16'hA803, 1'b0, 1'b0, 16'hA901, 1'b1},  // R7 source held
        {16'h0003, 1'b0, 1'b0, 16'h0001, 1'b0},  // R7 held on disabling write
        {16'h8009, 1'b0, 1'b0, 16'h8009, 1'b0},  // R5 reserved code
        {16'hFDF7, 1'b0, 1'b0, 16'hB907, 1'b1}   // R8 reserved bits dropped
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic scan(input int n, input bit use_pin,
                        output int minr, output int maxr, output int highs, output int toggles);
        logic prev, cur;
        int   runlen;
        bit   first;
        minr = 1 << 30; maxr = 0; highs = 0; toggles = 0; runlen = 0; first = 1; prev = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur = use_pin ? ref_pin : ref_clk;
            if (cur) highs++;
            if (i > 0 && cur != prev) begin
                toggles++;
                if (!first) begin
                    if (runlen < minr) minr = runlen;
                    if (runlen > maxr) maxr = runlen;
                end
                first = 0;
                runlen = 1;
            end else begin
                runlen++;
            end
            prev = cur;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mn, mx, hi, tg;
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        bus_addr = 1'b0;
        #1 chk("R1 ctrl", bus_rdata, 16'h0000);
        chk("R1 outputs", {ref_clk, ref_pin, ref_active}, 0);
        bus_addr = 1'b1;
        #1 chk("R1 div", bus_rdata, 16'h0000);
        bus_addr = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_req  = VEC[i][18];
            sleep_req = VEC[i][17];
            bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = VEC[i][34:19];
            @(negedge clk);
            bus_wr = 1'b0;
            #1;
            chk($sformatf("R2/R3/R4/R5/R7/R8 row %0d rdata", i), bus_rdata, VEC[i][16:1]);
            chk($sformatf("R2 row %0d active", i), ref_active, VEC[i][0]);
        end
        idle_req = 1'b0; sleep_req = 1'b0;

        // R8 divisor word bit 15
        wr_reg(1'b1, 16'hFFFF);
        bus_addr = 1'b1;
        #1 chk("R8 div bit15", bus_rdata, 16'h7FFF);
        bus_addr = 1'b0;

        // R10 load while stopped
        wr_reg(1'b0, 16'h0000);
        wr_reg(1'b1, 16'd2);
        wr_reg(1'b0, 16'h0200);
        #1 chk("R10 req pending", bus_rdata, 16'h0200);
        @(negedge clk);
        #1 chk("R10 req cleared when stopped", bus_rdata, 16'h0000);

        // R9 divide by 4
        src_tick = 8'h01;
        wr_reg(1'b0, 16'h9000);
        scan(4, 1'b1, mn, mx, hi, tg);
        scan(40, 1'b1, mn, mx, hi, tg);
        chk("R9 div2 min phase", mn, 2);
        chk("R9 div2 max phase", mx, 2);

        // R10 change while running
        wr_reg(1'b1, 16'd3);
        wr_reg(1'b0, 16'h9200);
        #1 chk("R10 req set", bus_rdata[9], 1);
        scan(40, 1'b0, mn, mx, hi, tg);
        chk("R10 no short phase", (mn >= 2 && mx <= 3), 1);
        #1 chk("R10 req cleared after wrap", bus_rdata[9], 0);
        scan(40, 1'b0, mn, mx, hi, tg);
        chk("R10 new phase min", mn, 3);
        chk("R10 new phase max", mx, 3);

        // R6 pin gating
        wr_reg(1'b0, 16'h8000);
        scan(20, 1'b1, mn, mx, hi, tg);
        chk("R6 pin held low", hi, 0);
        scan(20, 1'b0, mn, mx, hi, tg);
        chk("R6 internal clock runs", (tg > 0), 1);

        // R11 output low when stopped
        wr_reg(1'b0, 16'h0000);
        @(negedge clk);
        scan(10, 1'b0, mn, mx, hi, tg);
        chk("R11 low after stop", hi, 0);

        // R9 passthrough with divisor 0
        wr_reg(1'b1, 16'd0);
        wr_reg(1'b0, 16'h0200);
        @(negedge clk);
        src_tick = 8'h00;
        wr_reg(1'b0, 16'h8000);
        pat = 8'b10110010;
        src_tick[0] = pat[0];
        for (int b = 1; b < 8; b++) begin
            @(negedge clk);
            chk($sformatf("R9 passthrough bit %0d", b - 1), ref_clk, pat[b-1]);
            src_tick[0] = pat[b];
        end

        // R5 source routing
        wr_reg(1'b0, 16'h0000);
        wr_reg(1'b1, 16'd1);
        wr_reg(1'b0, 16'h0200);
        @(negedge clk);
        src_tick = 8'h08;
        wr_reg(1'b0, 16'h8003);
        scan(20, 1'b0, mn, mx, hi, tg);
        chk("R5 code 3 uses tick 3", (tg > 0), 1);
        wr_reg(1'b0, 16'h0000);
        wr_reg(1'b0, 16'h8002);
        scan(20, 1'b0, mn, mx, hi, tg);
        chk("R5 code 2 ignores tick 3", tg, 0);
        chk("R5 code 2 active", ref_active, 1);
        wr_reg(1'b0, 16'h0000);
        src_tick = 8'hFF;
        wr_reg(1'b0, 16'h800A);
        scan(20, 1'b0, mn, mx, hi, tg);
        chk("R5 reserved no clock", hi, 0);
        chk("R5 reserved inactive", ref_active, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule